// File: doc/BRIEF.md
# Configuration Request Intercept Responder

This block sits on the application side of a PCIe endpoint. The core presents intercepted configuration reads and writes to it one at a time. A one-cycle request strobe marks the cycle in which the dword address, the first-dword byte enables, the write flag, the write payload and the target identity are valid. The target identity is a function number, or a virtual-function number when the VF-active flag is set.

The block keeps a shadow copy of a small window of emulated dword registers. Each function and each virtual function has its own copy. In the cycle after a request that falls inside the window, the block asserts override-enable and drives the override data. For a read, the override data is the stored shadow word, which the core uses as the completion payload. For a write, the override data is the stored word with the enabled bytes replaced by the new payload. That merged word is also written back to the shadow. Requests outside the window, or aimed at a function or VF that has no shadow set, get no override, so the core handles them itself. The block raises halt for exactly one cycle after every accepted request, which keeps the core from issuing the next request while the answer is still on the wires.

The controller has two states. In `ST_IDLE` the block waits. Transition T1 (`ST_IDLE` to `ST_RESPOND`) occurs on a request strobe; the request is captured and decoded in that same edge. In `ST_RESPOND` halt is high and the override outputs are driven. Transition T2 (`ST_RESPOND` to `ST_IDLE`) is unconditional after one cycle. A synchronous reset forces `ST_IDLE` and clears every shadow word.

Top module: `cfg_intercept_responder`

## Requirements
- R1: When `rst` is high at a clock edge, the block is in the idle state after that edge, with `halt_o`, `override_en_o` and `override_data_o` all zero. Every shadow word reads back as zero afterwards.
- R2: `override_en_o` is high only in the cycle right after a request strobe, and only when that request hit the emulated window of an existing shadow set. Whenever `override_en_o` is low, `override_data_o` is zero.
- R3: For a request whose dword address lies outside [EMU_BASE, EMU_BASE+EMU_REGS) (defaults 0x0B0 to 0x0B3), `override_en_o` stays low and no shadow word changes.
- R4: For an emulated read, `override_data_o` in the cycle after the strobe equals the current shadow word of the selected set and register (register index = address − EMU_BASE).
- R5: For an emulated write, byte k of the result is taken from the payload when byte-enable bit k is 1, and from the old shadow word otherwise. Byte k occupies bits [8k+7:8k], and byte 0 is the first payload byte. The merged word is driven on `override_data_o` in the cycle after the strobe and is stored in the shadow.
- R6: `halt_o` is high for exactly the one cycle after each accepted request and low at all other times. The core never strobes a request while `halt_o` is high.
- R7: With `vf_active_i` low, the set is selected by `func_num_i`. With `vf_active_i` high, it is set NUM_FN + `vf_num_i`, and `func_num_i` is ignored. Different sets hold independent values.
- R8: A request with `vf_active_i` low and `func_num_i` ≥ NUM_FN (default 2), or with `vf_active_i` high and `vf_num_i` ≥ NUM_VF (default 4), gets no override and changes no shadow word.
- R9: An emulated write with all byte enables zero leaves the shadow word unchanged and drives its old value as override data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Intercepted request strobe; all other request fields valid in this cycle |
| addr_i | input | 10 | Dword register address |
| first_be_i | input | 4 | First-dword byte enables; bit k covers data bits [8k+7:8k] |
| wr_i | input | 1 | High for a configuration write; `wdata_i` valid |
| wdata_i | input | 32 | Write payload, little-endian |
| func_num_i | input | 3 | Target function number |
| vf_active_i | input | 1 | Request targets a virtual function |
| vf_num_i | input | 7 | Target virtual-function number |
| override_en_o | output | 1 | Core must use `override_data_o` instead of its own data |
| override_data_o | output | 32 | Replacement write data or completion payload |
| halt_o | output | 1 | Core must not issue a request this cycle |

## Verification
The assertions assume that the core obeys halt: no request strobe arrives while `halt_o` is high. They also assume the request fields are meaningful only in the strobe cycle. The stimulus tasks meet both conditions. Each task raises the strobe for a single cycle and then waits through the halt cycle before the next request is allowed. As a result, back-to-back traffic is always spaced two cycles apart. Fields that are not in use are left at arbitrary values so that the block does not depend on them.

// File: rtl/cfgi_pkg.sv
package cfgi_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_RESPOND = 1'b1
    } cfgi_state_e;
endpackage

// File: rtl/cfgi_decode.sv
module cfgi_decode #(
    parameter int ADDR_W   = 10,
    parameter int FN_W     = 3,
    parameter int VF_W     = 7,
    parameter int NUM_FN   = 2,
    parameter int NUM_VF   = 4,
    parameter int EMU_BASE = 176,
    parameter int EMU_REGS = 4,
    parameter int SET_W    = 3,
    parameter int REG_W    = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [FN_W-1:0]   func_num_i,
    input  logic              vf_active_i,
    input  logic [VF_W-1:0]   vf_num_i,
    output logic              hit_o,
    output logic [SET_W-1:0]  set_o,
    output logic [REG_W-1:0]  reg_o
);
    logic [31:0] addr_w;
    logic        in_window;
    logic        fn_ok;
    logic        vf_ok;

    always_comb begin
        addr_w    = 32'(addr_i);
        in_window = (addr_w >= 32'(EMU_BASE)) && (addr_w < 32'(EMU_BASE + EMU_REGS));
        fn_ok     = 32'(func_num_i) < 32'(NUM_FN);
        vf_ok     = 32'(vf_num_i) < 32'(NUM_VF);
        hit_o     = in_window && (vf_active_i ? vf_ok : fn_ok);
        set_o     = vf_active_i ? SET_W'(32'(NUM_FN) + 32'(vf_num_i)) : SET_W'(func_num_i);
        reg_o     = REG_W'(addr_w - 32'(EMU_BASE));
    end
endmodule

// File: rtl/cfgi_byte_merge.sv
module cfgi_byte_merge #(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic [BE_W-1:0]   be_i,
    input  logic [DATA_W-1:0] new_i,
    input  logic [DATA_W-1:0] old_i,
    output logic [DATA_W-1:0] merged_o
);
    localparam int LANE_W = cfgi_pkg::BYTE_W;

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign merged_o[b*LANE_W +: LANE_W] = be_i[b] ? new_i[b*LANE_W +: LANE_W]
                                                      : old_i[b*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/cfgi_shadow.sv
module cfgi_shadow #(
    parameter int DATA_W   = 32,
    parameter int NUM_SETS = 6,
    parameter int EMU_REGS = 4,
    parameter int SET_W    = 3,
    parameter int REG_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [SET_W-1:0]  set_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int ENTRIES = NUM_SETS * EMU_REGS;
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [DATA_W-1:0] words_q [ENTRIES];
    logic [IDX_W-1:0]  idx;
    logic              idx_ok;

    always_comb begin
        idx    = IDX_W'(32'(set_i) * 32'(EMU_REGS) + 32'(reg_i));
        idx_ok = (32'(set_i) < 32'(NUM_SETS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                words_q[e] <= '0;
            end
        end else if (wr_en_i && idx_ok) begin
            words_q[idx] <= wdata_i;
        end
    end

    assign rdata_o = idx_ok ? words_q[idx] : '0;
endmodule

// File: rtl/cfg_intercept_responder.sv
module cfg_intercept_responder #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int BE_W     = 4,
    parameter int FN_W     = 3,
    parameter int VF_W     = 7,
    parameter int NUM_FN   = 2,
    parameter int NUM_VF   = 4,
    parameter int EMU_BASE = 176,
    parameter int EMU_REGS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   first_be_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [FN_W-1:0]   func_num_i,
    input  logic              vf_active_i,
    input  logic [VF_W-1:0]   vf_num_i,
    output logic              override_en_o,
    output logic [DATA_W-1:0] override_data_o,
    output logic              halt_o
);
    import cfgi_pkg::*;

    localparam int NUM_SETS = NUM_FN + NUM_VF;
    localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
    localparam int REG_W    = (EMU_REGS > 1) ? $clog2(EMU_REGS) : 1;

    cfgi_state_e       state_q, state_d;
    logic              hit_d;
    logic [SET_W-1:0]  set_d;
    logic [REG_W-1:0]  reg_d;
    logic              hit_q;
    logic              wr_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [SET_W-1:0]  set_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] shadow_rd;
    logic [DATA_W-1:0] merged;
    logic              shadow_we;
    logic              accept;

    cfgi_decode #(
        .ADDR_W(ADDR_W), .FN_W(FN_W), .VF_W(VF_W),
        .NUM_FN(NUM_FN), .NUM_VF(NUM_VF),
        .EMU_BASE(EMU_BASE), .EMU_REGS(EMU_REGS),
        .SET_W(SET_W), .REG_W(REG_W)
    ) decode_i (
        .addr_i(addr_i), .func_num_i(func_num_i),
        .vf_active_i(vf_active_i), .vf_num_i(vf_num_i),
        .hit_o(hit_d), .set_o(set_d), .reg_o(reg_d)
    );

    cfgi_shadow #(
        .DATA_W(DATA_W), .NUM_SETS(NUM_SETS), .EMU_REGS(EMU_REGS),
        .SET_W(SET_W), .REG_W(REG_W)
    ) shadow_i (
        .clk(clk), .rst(rst), .wr_en_i(shadow_we),
        .set_i(set_q), .reg_i(reg_q), .wdata_i(merged), .rdata_o(shadow_rd)
    );

    cfgi_byte_merge #(.DATA_W(DATA_W), .BE_W(BE_W)) merge_i (
        .be_i(be_q), .new_i(wdata_q), .old_i(shadow_rd), .merged_o(merged)
    );

    assign accept    = (state_q == ST_IDLE) && req_i;
    assign shadow_we = (state_q == ST_RESPOND) && hit_q && wr_q;

    // Next-state logic: T1 on a strobe, T2 unconditional.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_i) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Request capture at the strobe edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q   <= 1'b0;
            wr_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
            set_q   <= '0;
            reg_q   <= '0;
        end else if (accept) begin
            hit_q   <= hit_d;
            wr_q    <= wr_i;
            be_q    <= first_be_i;
            wdata_q <= wdata_i;
            set_q   <= set_d;
            reg_q   <= reg_d;
        end
    end

    // Outputs from state.
    always_comb begin
        halt_o          = 1'b0;
        override_en_o   = 1'b0;
        override_data_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                halt_o = 1'b0;
            end
            ST_RESPOND: begin
                halt_o          = 1'b1;
                override_en_o   = hit_q;
                override_data_o = hit_q ? (wr_q ? merged : shadow_rd) : '0;
            end
            default: begin
                halt_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cfgi_intercept_checker.sv
module cfgi_intercept_checker #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int EMU_BASE = 176,
    parameter int EMU_REGS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              override_en_o,
    input logic [DATA_W-1:0] override_data_o,
    input logic              halt_o
);
    logic outside;
    assign outside = (32'(addr_i) < 32'(EMU_BASE)) || (32'(addr_i) >= 32'(EMU_BASE + EMU_REGS));

    p_ovr_after_req_r2: assert property (@(posedge clk) disable iff (rst)
        override_en_o |-> $past(req_i));
    p_ovr_quiet_data_r2: assert property (@(posedge clk) disable iff (rst)
        !override_en_o |-> (override_data_o == '0));
    p_ovr_in_halt_r2: assert property (@(posedge clk) disable iff (rst)
        override_en_o |-> halt_o);
    p_outside_no_ovr_r3: assert property (@(posedge clk) disable iff (rst)
        (req_i && !halt_o && outside) |=> !override_en_o);
    p_halt_follows_req_r6: assert property (@(posedge clk) disable iff (rst)
        (req_i && !halt_o) |=> halt_o);
    p_halt_single_r6: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> !halt_o);
    p_halt_has_cause_r6: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> $past(req_i));
    p_no_req_in_halt_r6: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> !req_i);
endmodule

bind cfg_intercept_responder cfgi_intercept_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EMU_BASE(EMU_BASE), .EMU_REGS(EMU_REGS)
) chk_i (
    .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i),
    .override_en_o(override_en_o), .override_data_o(override_data_o), .halt_o(halt_o)
);

// File: tb/cfg_intercept_responder_tb_top.sv
`timescale 1ns/1ps
module cfg_intercept_responder_tb_top;
    localparam int BASE = 176;
    localparam int NREG = 4;
    localparam int NFN  = 2;
    localparam int NVF  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [9:0]  addr = '0;
    logic [3:0]  be = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [2:0]  fn = '0;
    logic        vfa = 1'b0;
    logic [6:0]  vfn = '0;
    logic        ovr_en;
    logic [31:0] ovr_data;
    logic        halt;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    armed  = 1'b0;
    string tag    = "R1";

    bit [31:0] sh [NFN+NVF][NREG];
    bit        e_en = 1'b0;
    bit        e_halt = 1'b0;
    bit [31:0] e_dat = '0;

    always #4 clk = ~clk;

    cfg_intercept_responder dut_i (
        .clk(clk), .rst(rst), .req_i(req), .addr_i(addr), .first_be_i(be),
        .wr_i(wr), .wdata_i(wdata), .func_num_i(fn), .vf_active_i(vfa),
        .vf_num_i(vfn), .override_en_o(ovr_en), .override_data_o(ovr_data),
        .halt_o(halt)
    );

    task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", t, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated at each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NFN + NVF; s++)
                for (int r = 0; r < NREG; r++) sh[s][r] = '0;
            e_en = 0; e_dat = '0; e_halt = 0;
            armed = 1'b1;
        end else if (!e_halt && req) begin
            int a, set;
            bit ok;
            bit [31:0] cur;
            e_halt = 1;
            a   = int'(addr);
            ok  = (a >= BASE) && (a < BASE + NREG) && (vfa ? (int'(vfn) < NVF) : (int'(fn) < NFN));
            set = vfa ? NFN + int'(vfn) : int'(fn);
            if (ok) begin
                cur = sh[set][a - BASE];
                if (wr) begin
                    for (int b = 0; b < 4; b++) if (be[b]) cur[8*b +: 8] = wdata[8*b +: 8];
                    sh[set][a - BASE] = cur;
                end
                e_en = 1; e_dat = cur;
            end else begin
                e_en = 0; e_dat = '0;
            end
        end else begin
            e_halt = 0; e_en = 0; e_dat = '0;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (armed) begin
            chk("R6", "halt", {31'd0, halt}, {31'd0, e_halt});
            chk("R2", "override_en", {31'd0, ovr_en}, {31'd0, e_en});
            chk(tag, "override_data", ovr_data, e_dat);
        end
    end

    task automatic op(input string t, input bit w, input int a, input bit [3:0] b,
                      input bit [31:0] d, input int f, input bit va, input int v);
        @(negedge clk);
        tag = t;
        req = 1'b1; wr = w; addr = 10'(a); be = b; wdata = d;
        fn = 3'(f); vfa = va; vfn = 7'(v);
        @(negedge clk);
        req = 1'b0; wdata = 32'hDEAD_BEEF; be = 4'hF; addr = 10'h3FF;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: quiet outputs straight after reset
        @(negedge clk);
        chk("R1", "reset halt", {31'd0, halt}, 32'd0);
        chk("R1", "reset override_en", {31'd0, ovr_en}, 32'd0);
        chk("R1", "reset data", ovr_data, 32'd0);
        op("R1", 0, BASE, 4'hF, 0, 0, 0, 0);
        // R5 full write, R4 read back
        op("R5", 1, BASE, 4'hF, 32'hAABBCCDD, 0, 0, 0);
        op("R4", 0, BASE, 4'hF, 0, 0, 0, 0);
        op("R5", 1, BASE, 4'b0101, 32'h11223344, 0, 0, 0);
        op("R4", 0, BASE, 4'h0, 0, 0, 0, 0);
        op("R5", 1, BASE + 3, 4'b1000, 32'h5A000000, 0, 0, 0);
        op("R4", 0, BASE + 3, 4'hF, 0, 0, 0, 0);
        // R9 zero byte enables
        op("R9", 1, BASE, 4'h0, 32'hFFFFFFFF, 0, 0, 0);
        op("R9", 0, BASE, 4'hF, 0, 0, 0, 0);
        // R7 independent sets
        op("R7", 1, BASE, 4'hF, 32'h01010101, 1, 0, 0);
        op("R7", 1, BASE, 4'hF, 32'h02020202, 5, 1, 2);
        op("R7", 0, BASE, 4'hF, 0, 1, 0, 0);
        op("R7", 0, BASE, 4'hF, 0, 0, 1, 2);
        op("R7", 0, BASE, 4'hF, 0, 0, 0, 0);
        op("R7", 0, BASE, 4'hF, 0, 7, 1, 3);
        // R8 no shadow set
        op("R8", 1, BASE, 4'hF, 32'h77777777, 3, 0, 0);
        op("R8", 1, BASE, 4'hF, 32'h66666666, 0, 1, 5);
        op("R8", 0, BASE, 4'hF, 0, 0, 1, 5);
        op("R8", 0, BASE, 4'hF, 0, 0, 0, 0);
        // R3 outside the window on both sides
        op("R3", 1, BASE - 1, 4'hF, 32'h12345678, 0, 0, 0);
        op("R3", 1, BASE + NREG, 4'hF, 32'h87654321, 0, 0, 0);
        op("R3", 0, BASE + NREG, 4'hF, 0, 0, 0, 0);
        op("R3", 0, BASE, 4'hF, 0, 0, 0, 0);
        // R6 back-to-back traffic
        for (int i = 0; i < 8; i++)
            op("R6", i[0], BASE + (i % NREG), 4'(i), 32'(i * 32'h01030507), i % 2, 1'(i / 4), i % 4);
        repeat (2) @(negedge clk);
        // R1 mid-run reset clears shadows
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        op("R1", 0, BASE, 4'hF, 0, 0, 0, 0);
        op("R1", 0, BASE, 4'hF, 0, 1, 0, 0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule